// File: doc/BRIEF.md
# Instrument Status Byte Reporter

This block is the status reporting core of a programmable instrument, built along the lines of the IEEE 488.2 status model. It keeps a sticky 8-bit standard event register, gates it through an event enable mask, and folds the result into the event summary bit of a status byte. The status byte is then gated through a service request enable mask. This gives a live master summary bit and a latched request-service bit, and the latched bit drives the service request line.

The command decoder outside the block issues single-cycle strobes. These load the two masks, read and clear the event register, query the status byte, perform a serial poll, mark a program message terminator and issue a clear-status command. The output queue supplies a message-available level. Other summary sources supply bits 7 and 3..0 of the status byte as levels. The block offers two views of the status byte. The query view carries the master summary bit in bit 6, and the poll view carries the latched request bit there.

Top module: `srs_status_top`

## Requirements
- R1: Out of reset the event register reads 8'h80 (power-on bit 7 set), both masks read 0, srq_o is 0 and both byte views are 0 while all status inputs are low.
- R2: A one-cycle pulse on evt_pulse_i[n] sets event bit n from the next cycle on, and the bit holds until a clear. Event bits 6 and 1 always read 0.
- R3: Status bit 5 is 1 exactly when some event bit and its event enable bit are both 1. An event whose enable bit is 0 raises neither bit 5 nor srq_o.
- R4: Bit 6 of stb_o (the master summary) is 1 when any status bit other than bit 6 is 1 together with its service request enable bit.
- R5: The request bit is set on the cycle after the master summary rises. srq_o equals the request bit, and bit 6 of spoll_o shows it.
- R6: A serial poll strobe clears only the request bit, from the next cycle on. The request bit is set again only after a new rising edge of the master summary. A rising edge on the same cycle as the poll wins.
- R7: A status query strobe changes no bit of the event register, the status byte or the request bit.
- R8: A clear-status strobe clears every event bit, including bit 7, from the next cycle on, so status bit 5 drops. Without a preceding terminator, status bit 4 still follows mav_i.
- R9: A clear-status strobe issued when the last strobe was a terminator strobe raises oq_flush_o during that cycle. Status bit 4 then reads 0 from the next cycle until mav_i has been seen low.
- R10: An event read-and-clear strobe clears the event register from the next cycle on. An event pulse on the same cycle is kept.
- R11: Load strobes write wr_data_i into the event enable or service request enable mask from the next cycle on. Bit 6 of the service request enable mask always reads 0.
- R12: Status bit 4 follows mav_i. Status bits 7 and 3..0 follow ext_sum_i[4] and ext_sum_i[3:0] in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | 8 | One-cycle event pulses, one per event bit |
| mav_i | input | 1 | Message available level from the output queue |
| ext_sum_i | input | 5 | Summary levels for status bits 7 (bit 4) and 3..0 |
| wr_data_i | input | 8 | Data for the mask load strobes |
| ese_wr_i | input | 1 | Load event enable mask |
| sre_wr_i | input | 1 | Load service request enable mask |
| esr_rd_i | input | 1 | Read-and-clear of the event register |
| cls_i | input | 1 | Clear-status command |
| term_i | input | 1 | Program message terminator seen |
| stb_qry_i | input | 1 | Status byte query |
| spoll_i | input | 1 | Serial poll |
| esr_o | output | 8 | Event register read-back |
| ese_o | output | 8 | Event enable mask read-back |
| sre_o | output | 8 | Service request enable mask read-back |
| stb_o | output | 8 | Status byte, master summary in bit 6 |
| spoll_o | output | 8 | Status byte, request bit in bit 6 |
| srq_o | output | 1 | Service request line |
| oq_flush_o | output | 1 | Output queue flush request |

## Verification
Register writes, event pulses and clears show up on esr_o, ese_o and sre_o one cycle after the strobe. Status bits 5 and 6 of stb_o are combinational from these registers, so they change in that same cycle. Status bit 4 follows mav_i in the same cycle. srq_o and bit 6 of spoll_o follow one cycle later still, so they arrive two cycles after an event pulse and one cycle after a poll. oq_flush_o is combinational and is sampled inside the cycle of the strobe. The bench drives inputs on the falling edge and samples outputs on a later falling edge, with its expected values placed on exactly these cycles.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int BYTE_W  = 8;
  localparam int EXT_W   = 5;
  localparam int ESB_BIT = 5;
  localparam int MAV_BIT = 4;
  localparam int SUM_BIT = 6;
  localparam int PON_BIT = 7;
  localparam logic [BYTE_W-1:0] ESR_FIXED0 = 8'h42;
  localparam logic [BYTE_W-1:0] SRE_FIXED0 = 8'h40;
  localparam logic [BYTE_W-1:0] ESR_RST    = 8'h80;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/srs_evt_reg.sv
module srs_evt_reg #(
  parameter int                W         = 8,
  parameter logic [W-1:0]      RST_VAL   = '0,
  parameter logic [W-1:0]      ZERO_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (ZERO_MASK[i]) begin : g_fixed
      assign q_o[i] = 1'b0;
    end else begin : g_sticky
      logic bit_q;
      // set beats clear so a same-cycle event is not lost
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        bit_q <= RST_VAL[i];
        else if (set_i[i])  bit_q <= 1'b1;
        else if (clr_i)     bit_q <= 1'b0;
      end
      assign q_o[i] = bit_q;
    end
  end
endmodule

// File: rtl/srs_mask_reg.sv
module srs_mask_reg #(
  parameter int           W         = 8,
  parameter logic [W-1:0] ZERO_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (ld_i) q <= d_i & ~ZERO_MASK;
  end
  assign q_o = q;
endmodule

// File: rtl/srs_req_ctl.sv
module srs_req_ctl #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_i,
  input  logic         poll_i,
  output logic         mss_o,
  output logic         rqs_o
);
  logic mss, mss_q, rqs_q, rise;
  assign mss  = |(src_i & en_i);
  assign rise = mss & ~mss_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss;
      if (rise)        rqs_q <= 1'b1;
      else if (poll_i) rqs_q <= 1'b0;
    end
  end
  assign mss_o = mss;
  assign rqs_o = rqs_q;
endmodule

// File: rtl/srs_mav_ctl.sv
module srs_mav_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mav_i,
  input  logic cls_i,
  input  logic term_i,
  input  logic other_cmd_i,
  output logic mav_o,
  output logic flush_o
);
  logic term_q, hold_q, flush;
  assign flush = cls_i & term_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (term_i)                    term_q <= 1'b1;
      else if (other_cmd_i || cls_i) term_q <= 1'b0;
      // mask stale availability until the queue reports empty
      if (flush)       hold_q <= 1'b1;
      else if (!mav_i) hold_q <= 1'b0;
    end
  end
  assign mav_o   = mav_i & ~hold_q;
  assign flush_o = flush;
endmodule

// File: rtl/srs_status_top.sv
module srs_status_top
  import srs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] evt_pulse_i,
  input  logic              mav_i,
  input  logic [EXT_W-1:0]  ext_sum_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ese_wr_i,
  input  logic              sre_wr_i,
  input  logic              esr_rd_i,
  input  logic              cls_i,
  input  logic              term_i,
  input  logic              stb_qry_i,
  input  logic              spoll_i,
  output logic [BYTE_W-1:0] esr_o,
  output logic [BYTE_W-1:0] ese_o,
  output logic [BYTE_W-1:0] sre_o,
  output logic [BYTE_W-1:0] stb_o,
  output logic [BYTE_W-1:0] spoll_o,
  output logic              srq_o,
  output logic              oq_flush_o
);
  byte_t esr, ese, sre, stb_base;
  logic  esb, mav, mss, rqs, other_cmd;

  srs_evt_reg #(.W(BYTE_W), .RST_VAL(ESR_RST), .ZERO_MASK(ESR_FIXED0)) u_esr (
    .clk_i, .rst_ni, .set_i(evt_pulse_i), .clr_i(cls_i | esr_rd_i), .q_o(esr)
  );

  srs_mask_reg #(.W(BYTE_W), .ZERO_MASK('0)) u_ese (
    .clk_i, .rst_ni, .ld_i(ese_wr_i), .d_i(wr_data_i), .q_o(ese)
  );

  srs_mask_reg #(.W(BYTE_W), .ZERO_MASK(SRE_FIXED0)) u_sre (
    .clk_i, .rst_ni, .ld_i(sre_wr_i), .d_i(wr_data_i), .q_o(sre)
  );

  assign other_cmd = ese_wr_i | sre_wr_i | esr_rd_i | stb_qry_i | spoll_i;

  srs_mav_ctl u_mav (
    .clk_i, .rst_ni, .mav_i, .cls_i, .term_i, .other_cmd_i(other_cmd),
    .mav_o(mav), .flush_o(oq_flush_o)
  );

  assign esb = |(esr & ese);

  always_comb begin
    stb_base            = '0;
    stb_base[3:0]       = ext_sum_i[3:0];
    stb_base[MAV_BIT]   = mav;
    stb_base[ESB_BIT]   = esb;
    stb_base[PON_BIT]   = ext_sum_i[4];
  end

  srs_req_ctl #(.W(BYTE_W)) u_req (
    .clk_i, .rst_ni, .src_i(stb_base), .en_i(sre), .poll_i(spoll_i),
    .mss_o(mss), .rqs_o(rqs)
  );

  always_comb begin
    stb_o            = stb_base;
    stb_o[SUM_BIT]   = mss;
    spoll_o          = stb_base;
    spoll_o[SUM_BIT] = rqs;
  end

  assign esr_o = esr;
  assign ese_o = ese;
  assign sre_o = sre;
  assign srq_o = rqs;
endmodule

// File: rtl/srs_status_chk.sv
module srs_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] evt_pulse_i,
  input logic       cls_i,
  input logic       esr_rd_i,
  input logic       stb_qry_i,
  input logic       spoll_i,
  input logic       ese_wr_i,
  input logic       sre_wr_i,
  input logic [7:0] esr_o,
  input logic [7:0] ese_o,
  input logic [7:0] sre_o,
  input logic [7:0] stb_o,
  input logic       srq_o,
  input logic       oq_flush_o
);
  // R2
  fixed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esr_o[6] == 1'b0 && esr_o[1] == 1'b0);
  // R2
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cls_i && !esr_rd_i) |=> ((esr_o & $past(esr_o)) == $past(esr_o)));
  // R3
  esb_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_pulse_i & ese_o & 8'hBD) && !ese_wr_i) |=> stb_o[5]);
  // R5
  rqs_after_mss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srq_o) |-> ($past(stb_o[6]) && !$past(srq_o)));
  // R6
  poll_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spoll_i && !(stb_o[6] && !$past(stb_o[6]))) |=> !srq_o);
  // R7
  query_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_qry_i && evt_pulse_i == 8'h00 && !cls_i && !esr_rd_i) |=> $stable(esr_o));
  // R8
  cls_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i && evt_pulse_i == 8'h00) |=> esr_o == 8'h00);
  // R9
  flush_mav_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oq_flush_o |=> !stb_o[4]);
  // R11
  sre_bit6_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sre_wr_i |=> sre_o[6] == 1'b0);
endmodule

bind srs_status_top srs_status_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_pulse_i(evt_pulse_i), .cls_i(cls_i),
  .esr_rd_i(esr_rd_i), .stb_qry_i(stb_qry_i), .spoll_i(spoll_i),
  .ese_wr_i(ese_wr_i), .sre_wr_i(sre_wr_i), .esr_o(esr_o), .ese_o(ese_o),
  .sre_o(sre_o), .stb_o(stb_o), .srq_o(srq_o), .oq_flush_o(oq_flush_o)
);

// File: tb/srs_status_top_tb.sv
module srs_status_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0, wdat = '0;
  logic       mav = 1'b0;
  logic [4:0] ext = '0;
  logic       ese_wr = 0, sre_wr = 0, esr_rd = 0, cls = 0, term = 0, qry = 0, poll = 0;
  logic [7:0] esr, ese, sre, stb, spb;
  logic       srq, flush;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  srs_status_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_pulse_i(evt), .mav_i(mav), .ext_sum_i(ext),
    .wr_data_i(wdat), .ese_wr_i(ese_wr), .sre_wr_i(sre_wr), .esr_rd_i(esr_rd),
    .cls_i(cls), .term_i(term), .stb_qry_i(qry), .spoll_i(poll),
    .esr_o(esr), .ese_o(ese), .sre_o(sre), .stb_o(stb), .spoll_o(spb),
    .srq_o(srq), .oq_flush_o(flush)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic clr_strobes();
    evt = '0; ese_wr = 0; sre_wr = 0; esr_rd = 0; cls = 0; term = 0; qry = 0; poll = 0;
  endtask

  task automatic load(input bit to_sre, input logic [7:0] d);
    wdat = d; if (to_sre) sre_wr = 1; else ese_wr = 1;
    step(); clr_strobes();
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    evt = e; step(); clr_strobes();
  endtask

  task automatic do_cls();
    cls = 1; step(); clr_strobes();
  endtask

  task automatic t_reset();
    chk("R1 esr", esr, 8'h80);
    chk("R1 ese", ese, 8'h00);
    chk("R1 sre", sre, 8'h00);
    chk("R1 srq", {7'd0, srq}, 8'h00);
    chk("R1 stb", stb, 8'h00);
    chk("R1 spoll", spb, 8'h00);
  endtask

  task automatic t_events();
    do_cls();
    chk("R8 pon cleared", esr, 8'h00);
    pulse_evt(8'hFF);
    chk("R2 set, 6/1 fixed", esr, 8'hBD);
    step(); step();
    chk("R2 sticky", esr, 8'hBD);
    chk("R3 masked esb", stb, 8'h00);
    chk("R3 masked srq", {7'd0, srq}, 8'h00);
    esr_rd = 1; evt = 8'h01; step(); clr_strobes();
    chk("R10 rd clear keeps same-cycle evt", esr, 8'h01);
    esr_rd = 1; step(); clr_strobes();
    chk("R10 rd clear", esr, 8'h00);
  endtask

  task automatic t_enables();
    load(1'b0, 8'h20);
    chk("R11 ese load", ese, 8'h20);
    load(1'b1, 8'hFF);
    chk("R11 sre bit6 ignored", sre, 8'hBF);
    load(1'b1, 8'h20);
    chk("R11 sre load", sre, 8'h20);
  endtask

  task automatic t_request();
    pulse_evt(8'h10);
    step();
    chk("R3 masked evt no esb", stb, 8'h00);
    chk("R3 masked evt no srq", {7'd0, srq}, 8'h00);
    pulse_evt(8'h20);
    chk("R3 esb", stb, 8'h60);
    chk("R4 mss in stb", {7'd0, stb[6]}, 8'h01);
    chk("R5 srq not yet", {7'd0, srq}, 8'h00);
    step();
    chk("R5 srq", {7'd0, srq}, 8'h01);
    chk("R5 spoll view", spb, 8'h60);
  endtask

  task automatic t_poll();
    poll = 1; step(); clr_strobes();
    chk("R6 rqs cleared", {7'd0, srq}, 8'h00);
    chk("R6 spoll view", spb, 8'h20);
    chk("R6 stb keeps mss", stb, 8'h60);
    chk("R6 esr kept", esr, 8'h30);
    step(); step(); step();
    chk("R6 no re-set w/o new rise", {7'd0, srq}, 8'h00);
  endtask

  task automatic t_query();
    do_cls();
    chk("R8 esb drops", stb, 8'h00);
    pulse_evt(8'h20); step();
    chk("R5 re-set after new rise", {7'd0, srq}, 8'h01);
    qry = 1; step(); clr_strobes();
    chk("R7 query srq", {7'd0, srq}, 8'h01);
    chk("R7 query esr", esr, 8'h20);
    chk("R7 query stb", stb, 8'h60);
  endtask

  task automatic t_cls_mav();
    load(1'b1, 8'h00);
    mav = 1; step();
    chk("R12 mav bit", stb, 8'h30);
    cls = 1; #1;
    chk("R8 no flush w/o term", {7'd0, flush}, 8'h00);
    step(); clr_strobes();
    chk("R8 mav kept", stb, 8'h10);
    term = 1; step(); clr_strobes();
    qry = 1; step(); clr_strobes();
    cls = 1; #1;
    chk("R9 no flush after other cmd", {7'd0, flush}, 8'h00);
    step(); clr_strobes();
    term = 1; step(); clr_strobes();
    cls = 1; #1;
    chk("R9 flush", {7'd0, flush}, 8'h01);
    step(); clr_strobes();
    chk("R9 mav masked", stb, 8'h00);
    step();
    chk("R9 mav still masked", stb, 8'h00);
    mav = 0; step();
    mav = 1; step();
    chk("R9 mav back", stb, 8'h10);
    mav = 0;
  endtask

  task automatic t_ext();
    ext = 5'b1_0001; #1;
    chk("R12 ext bits", stb, 8'h81);
    load(1'b1, 8'h01);
    chk("R4 mss from ext", stb, 8'hC1);
    step();
    chk("R5 srq from ext", {7'd0, srq}, 8'h01);
    ext = 5'b0_0000; step();
    chk("R4 mss drops", stb, 8'h00);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_events();
    t_enables();
    t_request();
    t_poll();
    t_query();
    t_cls_mav();
    t_ext();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(posedge clk);
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule